// File: doc/BRIEF.md
# Field Difference Motion Detector

This block measures how much the luminance changes between two successive video fields. A source supplies one pixel pair per clock: the sample from the current field and the sample at the same position in the previous field. For each pair qualified as active video, the block takes the magnitude of the difference between the upper four bits of the two samples and adds it to a saturating field accumulator. A cadence detector elsewhere reads the resulting figure once per field to work out whether the material came from film.

The pixel pair arrives as a valid/ready stream. Valid doubles as the active-video qualifier, and ready is held high, so the block never applies back-pressure. A source may present a pair on any cycle, and a pair with valid low counts as blanking. During field blanking, a capture strobe arrives asynchronously. It is synchronised, and on its rising edge the upper sixteen bits of the accumulator are copied into a result register while the accumulator restarts for the next field. Software-side logic reads the result as two bytes through a simple request/acknowledge port. Reading the low byte and then the high byte empties the register.

Top module: `field_diff_detector`

## Requirements
- R1: After reset the result register and the accumulator hold zero, reads of either result byte return 0, and `pix_ready` is high.
- R2: On every clock with `pix_valid` high, the accumulator grows by |cur[7:4] - prev[7:4]|, a value from 0 to 15. `pix_ready` stays high in every cycle.
- R3: A clock with `pix_valid` low adds nothing to the accumulator, whatever the pixel inputs carry.
- R4: When `cap_strobe` is first sampled high at clock edge k after being low at edge k-1, the result register takes accumulator bits [ACC_W-1:ACC_W-16] at edge k+2. Holding the strobe high causes no further capture.
- R5: At the capture edge, the accumulator is loaded with the contribution of that cycle's pixel pair alone. The next field therefore starts from zero.
- R6: The accumulator saturates at all ones instead of wrapping.
- R7: A cycle with `rd_req` high is answered on the next cycle by `rd_ack` high for one cycle. Read address 0x80 returns result bits [7:0], 0x81 returns bits [15:8], and any other address returns 0. `rd_data` is 0 whenever `rd_ack` is low.
- R8: A read of 0x81 that follows a read of 0x80 (since the last capture or clear) sets the result register to zero once the high byte has been returned.
- R9: A high-byte read with no low-byte read before it, repeated low-byte reads, and reads of other addresses leave the result register unchanged. Reads of other addresses do not break a pending low-then-high sequence.
- R10: If a capture and a clearing high-byte read fall on the same edge, the capture wins. The read still returns the old high byte, and a new low-then-high sequence is needed before the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel pair valid, also the active-video qualifier |
| pix_ready | output | 1 | Always high; no back-pressure |
| pix_cur | input | PIX_W | Luma sample of the current field |
| pix_prev | input | PIX_W | Luma sample at the same position in the previous field |
| cap_strobe | input | 1 | Asynchronous capture strobe, rising edge active |
| rd_req | input | 1 | Read request, one cycle per read |
| rd_addr | input | 8 | Read address (0x80 low byte, 0x81 high byte) |
| rd_ack | output | 1 | Read answer valid, one cycle after the request |
| rd_data | output | 8 | Returned byte, zero when `rd_ack` is low |

## Verification
The checker assumes that `rd_req` is a single-cycle request whose address is stable in that cycle. It also assumes `cap_strobe` stays high long enough for the synchroniser to see it, and that the accumulator only reaches all ones through valid pixels. The stimulus drives every input on the falling clock edge. It holds the strobe high for three cycles and issues one-cycle reads. It lines up a capture with a clearing read on purpose, and it reaches saturation with long runs of maximum-difference pixels under a reduced accumulator width.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
  localparam int RES_W = 16;
  localparam logic [7:0] ADDR_LO = 8'h80;
  localparam logic [7:0] ADDR_HI = 8'h81;

  typedef enum logic { SEQ_IDLE = 1'b0, SEQ_LO_DONE = 1'b1 } rd_seq_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];

  assign rise = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/diff_accum.sv
module diff_accum #(
  parameter int PIX_W = 8,
  parameter int MSB_N = 4,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] prev,
  input  logic             restart,
  output logic [ACC_W-1:0] acc
);
  logic [MSB_N-1:0] top_cur, top_prev, mag, contrib;
  logic [ACC_W:0]   sum;

  always_comb begin
    top_cur  = cur[PIX_W-1 -: MSB_N];
    top_prev = prev[PIX_W-1 -: MSB_N];
    mag      = (top_cur > top_prev) ? (top_cur - top_prev) : (top_prev - top_cur);
    contrib  = valid ? mag : '0;
    sum      = {1'b0, acc} + (ACC_W+1)'(contrib);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= ACC_W'(contrib);
    else if (sum[ACC_W]) acc <= '1;
    else              acc <= sum[ACC_W-1:0];
endmodule

// File: rtl/result_port.sv
module result_port
  import fdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RES_W-1:0] snap,
  input  logic             rd_req,
  input  logic [7:0]       rd_addr,
  output logic             rd_ack,
  output logic [7:0]       rd_data,
  output logic [RES_W-1:0] result,
  output logic             clr_fire
);
  rd_seq_t seq_q;
  logic    hit_lo, hit_hi;

  always_comb begin
    hit_lo   = rd_req && (rd_addr == ADDR_LO);
    hit_hi   = rd_req && (rd_addr == ADDR_HI);
    clr_fire = hit_hi && (seq_q == SEQ_LO_DONE) && !capture;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= rd_req;
      rd_data <= hit_lo ? result[7:0] : (hit_hi ? result[15:8] : 8'h00);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      result <= '0;
      seq_q  <= SEQ_IDLE;
    end else if (capture) begin
      result <= snap;
      seq_q  <= SEQ_IDLE;
    end else if (clr_fire) begin
      result <= '0;
      seq_q  <= SEQ_IDLE;
    end else if (hit_lo) begin
      seq_q  <= SEQ_LO_DONE;
    end
endmodule

// File: rtl/field_diff_detector.sv
module field_diff_detector
  import fdd_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int MSB_N       = 4,
  parameter int ACC_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_cur,
  input  logic [PIX_W-1:0] pix_prev,
  input  logic             cap_strobe,
  input  logic             rd_req,
  input  logic [7:0]       rd_addr,
  output logic             rd_ack,
  output logic [7:0]       rd_data
);
  localparam int SNAP_LSB = ACC_W - RES_W;

  logic             cap_pulse;
  logic             clr_fire;
  logic [ACC_W-1:0] acc_q;
  logic [RES_W-1:0] result_q;

  assign pix_ready = 1'b1;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cap_strobe), .rise(cap_pulse)
  );

  diff_accum #(.PIX_W(PIX_W), .MSB_N(MSB_N), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .valid(pix_valid), .cur(pix_cur),
    .prev(pix_prev), .restart(cap_pulse), .acc(acc_q)
  );

  result_port u_res (
    .clk(clk), .rst_n(rst_n), .capture(cap_pulse),
    .snap(acc_q[SNAP_LSB +: RES_W]), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .result(result_q), .clr_fire(clr_fire)
  );
endmodule

// File: rtl/fdd_checker.sv
module fdd_checker #(
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             rd_req,
  input logic             rd_ack,
  input logic [7:0]       rd_data,
  input logic             cap_pulse,
  input logic             clr_fire,
  input logic [ACC_W-1:0] acc_q,
  input logic [15:0]      result_q
);
  // R7
  rd_ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);
  // R7
  rd_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_ack);
  // R7
  rd_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ack |-> rd_data == 8'h00);
  // R4
  cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_pulse && !clr_fire) |=> $stable(result_q));
  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> result_q == 16'h0000);
  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&acc_q && !cap_pulse) |=> &acc_q);
  // R3
  idle_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !cap_pulse) |=> $stable(acc_q));
endmodule

bind field_diff_detector fdd_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .rd_req(rd_req),
  .rd_ack(rd_ack), .rd_data(rd_data), .cap_pulse(cap_pulse),
  .clr_fire(clr_fire), .acc_q(acc_q), .result_q(result_q)
);

// File: tb/sim_field_diff_detector.sv
`timescale 1ns/1ps
module sim_field_diff_detector;
  localparam int ACC_W = 18;
  localparam int SHIFT = ACC_W - 16;
  localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, cap_strobe = 1'b0, rd_req = 1'b0;
  logic [7:0] pix_cur = '0, pix_prev = '0, rd_addr = '0;
  logic pix_ready, rd_ack;
  logic [7:0] rd_data;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  field_diff_detector #(.ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_cur(pix_cur), .pix_prev(pix_prev), .cap_strobe(cap_strobe),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  longint m_acc = 0;
  int m_res = 0;
  bit m_lo = 0, m_ack = 0;
  int m_data = 0;
  bit sq[$] = '{0, 0, 0};

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int d, a, b;
    bit cap;
    cycles++;
    if (!rst_n) begin
      m_acc = 0; m_res = 0; m_lo = 0; m_ack = 0; m_data = 0;
      sq = '{0, 0, 0};
    end else begin
      cap = sq[1] && !sq[2];                         // R4 latency
      sq.push_front(cap_strobe);
      void'(sq.pop_back());
      a = pix_cur >> 4; b = pix_prev >> 4;
      d = pix_valid ? ((a > b) ? a - b : b - a) : 0; // R2, R3
      m_ack = rd_req;                                // R7
      m_data = !rd_req ? 0 : (rd_addr == 8'h80) ? (m_res & 8'hFF) :
               (rd_addr == 8'h81) ? ((m_res >> 8) & 8'hFF) : 0;
      if (cap) begin                                 // R10 capture first
        m_res = int'(m_acc >> SHIFT); m_lo = 0;
      end else if (rd_req && rd_addr == 8'h81 && m_lo) begin // R8
        m_res = 0; m_lo = 0;
      end else if (rd_req && rd_addr == 8'h80) m_lo = 1;     // R9
      if (cap) m_acc = d;                            // R5
      else if (m_acc + d > ACC_MAX) m_acc = ACC_MAX; // R6
      else m_acc = m_acc + d;
    end
    #1;
    cmp("rd_ack", rd_ack, m_ack);
    cmp("rd_data", rd_data, m_data);
    cmp("pix_ready", pix_ready, 1);
  end

  task automatic pixels(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: begin pix_valid = 1; pix_cur = 8'($urandom); pix_prev = 8'($urandom); end
        1: begin pix_valid = 1'($urandom); pix_cur = 8'hF3; pix_prev = 8'h0C; end
        default: begin pix_valid = 1; pix_cur = 8'hF0; pix_prev = 8'h00; end
      endcase
    end
    @(negedge clk); pix_valid = 0; pix_cur = 8'hFF; pix_prev = 8'h00;
  endtask

  task automatic strobe();
    @(negedge clk); cap_strobe = 1;
    repeat (3) @(negedge clk);
    cap_strobe = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] addr);
    @(negedge clk); rd_req = 1; rd_addr = addr;
    @(negedge clk); rd_req = 0; rd_addr = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; rd(8'h80); rd(8'h81);
    cur_req = "R2"; pixels(300, 0); strobe(); rd(8'h80); rd(8'h55); rd(8'h81);
    cur_req = "R3"; pixels(400, 1); strobe(); rd(8'h81);
    cur_req = "R9"; rd(8'h81); rd(8'h80); rd(8'h80); rd(8'h33); rd(8'h81);
    cur_req = "R8"; rd(8'h80); rd(8'h81);
    cur_req = "R4"; pixels(200, 0);
    @(negedge clk); cap_strobe = 1; pix_valid = 1; pix_cur = 8'hE0; pix_prev = 8'h10;
    repeat (20) @(negedge clk);
    pix_valid = 0; cap_strobe = 0;
    rd(8'h80); rd(8'h81);
    cur_req = "R5"; pixels(100, 0);
    @(negedge clk); cap_strobe = 1; pix_valid = 1; pix_cur = 8'hF0; pix_prev = 8'h00;
    repeat (5) @(negedge clk);
    cap_strobe = 0; pix_valid = 0;
    strobe(); rd(8'h80); rd(8'h81);
    cur_req = "R10"; pixels(150, 0); strobe(); rd(8'h80); pixels(50, 0);
    @(negedge clk); cap_strobe = 1;
    @(negedge clk);
    @(negedge clk); rd_req = 1; rd_addr = 8'h81;
    @(negedge clk); rd_req = 0; cap_strobe = 0;
    rd(8'h80); rd(8'h81); rd(8'h80);
    cur_req = "R6"; pixels(17600, 2); strobe(); rd(8'h80); rd(8'h81);
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || cycles > 150000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule